// File: doc/BRIEF.md
# Half-Step Predivided Clock Generator

This block makes a divided clock from one of three reference sources. Each source arrives as a one-cycle tick strobe that is synchronous to the block clock. The selected tick stream first passes through a predivider whose ratio can be 2, 2.5 or 3. The 2.5 ratio is built from alternating spans of three and two source ticks. A post-divider then spreads `div` predivided ticks over one output period. The output is high for the first `floor(div/2)` of those ticks and low for the rest.

Software writes one control word. The word selects the source, the predivider code, the divider value and an enable. A write only updates a pending copy. The pending copy becomes active while the block is idle, or at the end of an output period, when the output is low. A new setting therefore never produces a shortened or stretched pulse. An invalid setting, or a cleared enable, parks the output low once the running period has finished.

Top module: `frac_clk_div`

## Requirements
- R1: A write with `cfg_wr` high stores all of `cfg_wdata` as the pending word. Every field is replaced, so no part of an earlier word is merged in. The word layout is: bits 7:0 divider, bits 10:8 predivider code, bit 11 external select, bit 12 PLL2 select, bit 13 enable.
- R2: When bit 11 is 1, the external tick is the source. When bit 11 is 0, bit 12 picks `pll2_tick` (1) or `pll1_tick` (0).
- R3: Predivider code 4 gives one predivided tick per 2 source ticks, and code 6 gives one per 3. Code 5 alternates spans of 3 and 2 source ticks. As a result, any two consecutive output periods last exactly 5·div source ticks, and each single period lasts floor(5·div/2) or that plus one.
- R4: With codes 4 or 6, an output period (rising edge to rising edge) lasts code·div/2 source ticks. The output is high for (code/2)·floor(div/2) of those ticks.
- R5: A divider value outside 2..127 (including 0, 1, 128 and 200) keeps the output low.
- R6: A predivider code other than 4, 5 or 6 keeps the output low.
- R7: When the enable bit is cleared, the period already running completes, and the output then stays low with no further rising edge.
- R8: A word written mid-period takes effect at the next rising edge. The period in progress keeps its old length and source. The active setting never changes while the output is high.
- R9: After reset the output is low and the pending word is all zeros (disabled), so no edge appears until a valid word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External reference tick strobe |
| pll1_tick | input | 1 | First PLL tick strobe |
| pll2_tick | input | 1 | Second PLL tick strobe |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 14 | Control word value |
| clk_out | output | 1 | Divided, enable-gated output clock |

## Verification
The source strobes run at different densities: the external tick is random at one half, the first PLL tick is random at three quarters, and the second PLL tick fires every cycle. A period counted on the wrong source therefore gives a clearly wrong length, which makes source-select errors visible. Codes 4 and 6 are checked for exact period and high time, while code 5 is checked through the pair sum. This separates a true 2.5 ratio from a rounded 2 or 3. The divider values include both limits (2 and 127), the illegal values just outside them and random values in between. A rewrite mid-period shows whether the old period completes before the new source and ratio appear.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int DIV_W  = 8;
  localparam int CODE_W = 3;
  localparam int CFG_W  = DIV_W + CODE_W + 3;
  localparam int N_SRC  = 3;

  typedef struct packed {
    logic              en;
    logic              pll2;
    logic              ext;
    logic [CODE_W-1:0] code;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  function automatic logic cfg_ok(cfg_t c, logic [DIV_W-1:0] div_max);
    logic code_good;
    code_good = (c.code == CODE_W'(4)) || (c.code == CODE_W'(5)) ||
                (c.code == CODE_W'(6));
    return c.en && code_good && (c.div >= DIV_W'(2)) && (c.div <= div_max);
  endfunction
endpackage

// File: rtl/fcd_src_sel.sv
module fcd_src_sel #(
  parameter int N = 3
) (
  input  logic [N-1:0] ticks,
  input  logic         sel_ext,
  input  logic         sel_pll2,
  output logic         tick
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (sel_ext)       idx = IDX_W'(0);
    else if (sel_pll2) idx = IDX_W'(2);
    else               idx = IDX_W'(1);
    tick = ticks[idx];
  end
endmodule

// File: rtl/fcd_prediv.sv
module fcd_prediv #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_tick,
  input  logic [CODE_W-1:0] code,
  output logic              pre_tick
);
  // accumulator in half-tick units: each source tick adds two halves
  logic [CODE_W-1:0] acc_q, acc_d;
  logic [CODE_W:0]   sum, rem;

  always_comb begin
    sum      = {1'b0, acc_q} + (CODE_W + 1)'(2);
    rem      = sum - {1'b0, code};
    pre_tick = run && src_tick && (sum >= {1'b0, code});
    acc_d    = acc_q;
    if (!run)          acc_d = '0;
    else if (pre_tick) acc_d = rem[CODE_W-1:0];
    else if (src_tick) acc_d = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fcd_postdiv.sv
module fcd_postdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic             restart_ok,
  output logic             wrap,
  output logic             clk_out
);
  logic [DIV_W-1:0] cnt_q, cnt_d, cnt_inc, half;
  logic             idle_q, idle_d, out_q, out_d, last;

  always_comb begin
    half    = div >> 1;
    cnt_inc = cnt_q + DIV_W'(1);
    last    = idle_q || (cnt_inc == div);
    wrap    = run && tick && last;
    cnt_d   = cnt_q;
    out_d   = out_q;
    idle_d  = idle_q;
    if (!run) begin
      cnt_d  = '0;
      out_d  = 1'b0;
      idle_d = 1'b1;
    end else if (tick) begin
      idle_d = 1'b0;
      if (last) begin
        cnt_d = '0;
        out_d = restart_ok;
      end else begin
        cnt_d = cnt_inc;
        out_d = cnt_inc < half;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      idle_q <= idle_d;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int DIV_MAX = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick,
  input  logic             pll1_tick,
  input  logic             pll2_tick,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             clk_out
);
  localparam logic [DIV_W-1:0] DIV_LIM = DIV_W'(DIV_MAX);

  cfg_t pend_q, pend_d, act_q, act_d;
  logic pend_ok, act_ok, src_tick, pre_tick, wrap;

  always_comb begin
    pend_ok = cfg_ok(pend_q, DIV_LIM);
    act_ok  = cfg_ok(act_q, DIV_LIM);
    pend_d  = cfg_wr ? cfg_t'(cfg_wdata) : pend_q;
    act_d   = (!act_ok || wrap) ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  fcd_src_sel #(.N(N_SRC)) u_sel (
    .ticks    ({pll2_tick, pll1_tick, ext_tick}),
    .sel_ext  (act_q.ext),
    .sel_pll2 (act_q.pll2),
    .tick     (src_tick)
  );

  fcd_prediv #(.CODE_W(CODE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (act_ok),
    .src_tick (src_tick),
    .code     (act_q.code),
    .pre_tick (pre_tick)
  );

  fcd_postdiv #(.DIV_W(DIV_W)) u_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (act_ok),
    .tick       (pre_tick),
    .div        (act_q.div),
    .restart_ok (pend_ok),
    .wrap       (wrap),
    .clk_out    (clk_out)
  );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import fcd_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic act_ok,
  input cfg_t act_word,
  input logic pre_tick,
  input logic clk_out
);
  // R5, R6 and R7: without a valid active setting the output is driven low
  assert_invalid_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_ok |=> !clk_out);

  // R8: the active setting may not move while the output is high
  assert_no_switch_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok && clk_out) |=> (act_word == $past(act_word)));

  // R3: a predivided tick needs at least two source ticks
  assert_pre_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

  // R4: the output only moves on a predivided tick while running
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok && !pre_tick) |=> $stable(clk_out));
endmodule

bind frac_clk_div frac_clk_div_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .act_ok   (act_ok),
  .act_word (act_q),
  .pre_tick (pre_tick),
  .clk_out  (clk_out)
);

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
  logic        clk, rst_n, cfg_wr, clk_out;
  logic [2:0]  srcs;
  logic [13:0] cfg_wdata;
  int checks, errors, rises, cycles;
  int cnt[3], hi[3], per[3], perp[3], hip[3];
  logic prev_out;

  frac_clk_div dut_i (
    .clk(clk), .rst_n(rst_n), .ext_tick(srcs[0]), .pll1_tick(srcs[1]),
    .pll2_tick(srcs[2]), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .clk_out(clk_out)
  );

  initial begin clk = 0; forever #2.5 clk = ~clk; end

  initial begin
    srcs = 3'b000;
    forever begin
      @(posedge clk); #1;
      srcs[0] = ($urandom % 2) == 0;
      srcs[1] = ($urandom % 4) != 0;
      srcs[2] = 1'b1;
    end
  end

  // period monitor: tick seen at negedge N is consumed at posedge N+1
  initial begin
    rises = 0; prev_out = 0;
    for (int s = 0; s < 3; s++) begin cnt[s] = 0; hi[s] = 0; per[s] = 0; perp[s] = 0; hip[s] = 0; end
    forever begin
      @(negedge clk);
      cycles++;
      if (rst_n && clk_out && !prev_out) begin
        rises++;
        for (int s = 0; s < 3; s++) begin
          perp[s] = per[s]; per[s] = cnt[s]; hip[s] = hi[s]; cnt[s] = 0; hi[s] = 0;
        end
      end
      for (int s = 0; s < 3; s++) begin
        cnt[s] += int'(srcs[s]);
        if (clk_out) hi[s] += int'(srcs[s]);
      end
      prev_out = clk_out;
    end
  end

  function automatic logic [13:0] mk(bit en, int src, int code, int dv);
    logic [2:0] c; logic [7:0] d;
    c = code[2:0]; d = dv[7:0];
    return {en, src == 2, src == 0, c, d};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [13:0] w);
    @(posedge clk); #1; cfg_wr = 1; cfg_wdata = w;
    @(posedge clk); #1; cfg_wr = 0;
  endtask

  task automatic wait_rises(int n);
    int target = rises + n;
    int guard = 0;
    while (rises < target && guard < 4000) begin @(negedge clk); #1; guard++; end
    if (rises < target) chk(0, "R4 edge timeout", rises, target);
  endtask

  task automatic no_rise(int n, string req);
    int r0 = rises;
    repeat (n) @(negedge clk);
    #1;
    chk(rises == r0, req, rises - r0, 0);
    chk(clk_out == 1'b0, req, int'(clk_out), 0);
  endtask

  task automatic steady(int src, int code, int dv);
    int lo;
    write_cfg(mk(1, src, code, dv));
    wait_rises(3);
    if (code == 5) begin
      wait_rises(2);
      lo = (5 * dv) / 2;
      chk(per[src] + perp[src] == 5 * dv, "R2 R3 pair sum", per[src] + perp[src], 5 * dv);
      chk(per[src] == lo || per[src] == lo + 1, "R3 single period", per[src], lo);
    end else begin
      wait_rises(1);
      chk(per[src] == code * dv / 2, "R2 R4 period", per[src], code * dv / 2);
      chk(hip[src] == (code / 2) * (dv / 2), "R4 high time", hip[src], (code / 2) * (dv / 2));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    checks = 0; errors = 0; cycles = 0;
    cfg_wr = 0; cfg_wdata = '0; rst_n = 0;
    repeat (4) @(posedge clk);
    #1 chk(clk_out == 1'b0, "R9 reset low", int'(clk_out), 0);
    rst_n = 1;
    no_rise(100, "R9 idle after reset");

    // directed corners
    steady(0, 4, 10);
    steady(1, 6, 7);
    steady(2, 5, 3);
    steady(0, 5, 2);
    steady(2, 6, 127);
    steady(1, 4, 2);

    // R8 and R1: rewrite mid-period, source and ratio both change
    steady(0, 4, 10);
    wait_rises(1);
    write_cfg(mk(1, 2, 6, 6));
    wait_rises(1);
    chk(per[0] == 20, "R8 old period kept", per[0], 20);
    wait_rises(1);
    chk(per[2] == 18, "R1 R8 new word applied", per[2], 18);

    // R7: enable cleared mid-period
    wait_rises(1);
    write_cfg(mk(0, 2, 6, 6));
    no_rise(300, "R7 stop low");

    // R5 and R6 from idle and from running
    write_cfg(mk(1, 0, 4, 0));   no_rise(300, "R5 div 0");
    write_cfg(mk(1, 0, 4, 1));   no_rise(300, "R5 div 1");
    write_cfg(mk(1, 2, 4, 128)); no_rise(300, "R5 div 128");
    write_cfg(mk(1, 2, 4, 200)); no_rise(300, "R5 div 200");
    write_cfg(mk(1, 2, 3, 8));   no_rise(300, "R6 code 3");
    write_cfg(mk(1, 2, 7, 8));   no_rise(300, "R6 code 7");
    steady(2, 4, 5);
    write_cfg(mk(1, 2, 0, 5));   no_rise(300, "R6 code 0 while running");

    // random mix
    for (int k = 0; k < 14; k++)
      steady(int'($urandom % 3), 4 + int'($urandom % 3), 2 + int'($urandom % 39));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    chk(0, "watchdog", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule